// File: doc/BRIEF.md
# SPI Receive Buffer and Event Status Unit

This block is the status and interrupt side of a SPI controller. It holds the receive byte FIFO that the serial shifter fills, and it lets a CPU drain that FIFO with either a 32-bit access, which removes up to four bytes, or an 8-bit access, which removes one byte. The TX byte count comes from the transmit FIFO outside the block. The RX and TX fill thresholds come from the controller's configuration.

The block returns one 32-bit status word. The upper fields of that word carry live RX and TX byte counts. The lower bits hold sticky event flags: the RX level has crossed its threshold, the TX FIFO has room, or an incoming byte was lost. Software clears a flag by writing a one to its position. A separate mask word selects which flags drive the single interrupt line.

Top module: `spi_evt_status`

## Requirements
- R1: Bits 29:24 of `event_word` always show the RX FIFO byte count. Bits 21:16 show the `tx_count` input. Bits 31:30, 23:22, 15:12, 10 and 7:0 read as zero.
- R2: Event bit 9 (RX ready) becomes set one cycle after the RX byte count exceeds `rx_thr`. It stays set until it is cleared.
- R3: Event bit 8 (TX room) becomes set one cycle after the free TX space, `DEPTH - tx_count`, is at least `tx_thr`. It stays set until it is cleared.
- R4: A byte pushed while the RX FIFO already holds `DEPTH` bytes is dropped. The count does not change, and event bit 11 (RX overflow) is set at the next edge. Bit 11 stays set until it is cleared.
- R5: Writing `evt_clr_data` with `evt_clr_we` high clears each flag bit that holds a one in the written data, at the next edge. A flag whose condition still holds stays set. Zero bits in the written data leave their flags unchanged.
- R6: `irq` is high when any of the flag bits 11, 9 and 8 is set together with the same bit of the mask word. The mask word is loaded by `mask_we`. Mask bits at any other position have no effect.
- R7: A word read (`rd_word`) with four or more bytes stored returns the oldest byte in bits 31:24 and the next bytes below it, then removes four bytes.
- R8: A word read with one to three bytes stored returns those bytes left-justified with zero fill, and removes only those bytes.
- R9: A byte read (`rd_byte`) returns the oldest byte in bits 7:0 with zeros above and removes one byte. When `rd_word` and `rd_byte` are both high, the word read is the one performed.
- R10: A read of an empty RX FIFO returns zero and leaves the count at zero.
- R11: While reset is held, all flags and the mask are zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_push | input | 1 | Shifter delivers a received byte |
| rx_in | input | 8 | Received byte |
| tx_count | input | 6 | Bytes in the TX FIFO |
| rx_thr | input | 6 | RX ready threshold |
| tx_thr | input | 6 | TX room threshold |
| evt_clr_we | input | 1 | Write-one-to-clear strobe for the flags |
| evt_clr_data | input | 32 | Clear pattern |
| mask_we | input | 1 | Mask load strobe |
| mask_wdata | input | 32 | New mask word |
| rd_word | input | 1 | 32-bit read of the RX FIFO |
| rd_byte | input | 1 | 8-bit read of the RX FIFO |
| rd_data | output | 32 | Read data, valid during the read strobe |
| event_word | output | 32 | Counts and event flags |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench builds the block with the default `DEPTH` of 32. This makes a full FIFO and an overflow reachable in a few dozen pushes, and lets a full drain of eight word reads show that the dropped byte never entered. It keeps the thresholds at 3 and 4, so the threshold boundaries for RX ready and TX room sit one byte apart. It also covers reads that straddle fewer than four stored bytes.

// File: rtl/spi_evt_pkg.sv
// Shared constants for the SPI event status unit: field positions in the
// status word that software decodes, and the width of the count fields.
package spi_evt_pkg;
    localparam int unsigned CNT_W     = 6;
    localparam int unsigned RXCNT_LSB = 24;
    localparam int unsigned TXCNT_LSB = 16;
    localparam int unsigned OVF_BIT   = 11;
    localparam int unsigned RXR_BIT   = 9;
    localparam int unsigned TXR_BIT   = 8;
    localparam logic [31:0] FLAG_BITS = 32'h0000_0B00;

    typedef struct packed {
        logic ovf;
        logic rxr;
        logic txr;
    } evt_flags_t;
endpackage

// File: rtl/spi_evt_rxfifo.sv
// Receive byte FIFO with a CPU read port that removes one byte or up to four.
// Assumes DEPTH is a power of two and at most 63. A push that arrives when
// the FIFO is full is dropped and reported by the drop pulse.
module spi_evt_rxfifo #(
    parameter int unsigned DEPTH = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [7:0]                   din,
    input  logic                         rd_word,
    input  logic                         rd_byte,
    output logic [31:0]                  rd_data,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         drop
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic [7:0]    peek [4];
    logic [2:0]    take;
    logic          accept;

    // Accept a push only while space remains.
    assign accept = push && (count < CW'(DEPTH));
    assign drop   = push && (count == CW'(DEPTH));

    // Look at the four oldest stored bytes.
    always_comb begin
        for (int i = 0; i < 4; i++) begin
            peek[i] = mem[rd_ptr + AW'(i)];
        end
    end

    // Decide how many bytes this read removes; a word read wins.
    always_comb begin
        if (rd_word) begin
            take = (count >= CW'(4)) ? 3'd4 : 3'(count);
        end else if (rd_byte) begin
            take = (count != '0) ? 3'd1 : 3'd0;
        end else begin
            take = 3'd0;
        end
    end

    // Format the read data: left-justified for words, low byte for bytes.
    always_comb begin
        rd_data = '0;
        if (rd_word) begin
            for (int i = 0; i < 4; i++) begin
                if (3'(i) < take) rd_data[31 - 8*i -: 8] = peek[i];
            end
        end else if (take != 3'd0) begin
            rd_data[7:0] = peek[0];
        end
    end

    // Byte storage, written only on an accepted push.
    always_ff @(posedge clk) begin
        if (accept) mem[wr_ptr] <= din;
    end

    // Pointer and count bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (accept) wr_ptr <= wr_ptr + AW'(1);
            rd_ptr <= rd_ptr + AW'(take);
            count  <= count + CW'(accept) - CW'(take);
        end
    end

    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    assert_word_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_word && count >= CW'(4) && !push) |=> (count == $past(count) - CW'(4)));

    assert_empty_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && !push && (rd_word || rd_byte)) |=> (count == '0));
endmodule

// File: rtl/spi_evt_flags.sv
// Sticky event flags, mask and interrupt. Each flag is set by its condition
// and cleared by a write-one pattern, but a condition that still holds wins
// over the clear. Assumes counts fit in the shared count width.
module spi_evt_flags
    import spi_evt_pkg::*;
#(
    parameter int unsigned DEPTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] rx_thr,
    input  logic [CNT_W-1:0] tx_thr,
    input  logic             ovf_pulse,
    input  logic             clr_we,
    input  logic [31:0]      clr_data,
    input  logic             mask_we,
    input  logic [31:0]      mask_wdata,
    output logic [31:0]      event_word,
    output logic             irq
);
    evt_flags_t     flags, mask, cond, clr;
    logic [CNT_W:0] tx_free;

    // Free TX space, saturating at zero for an out-of-range count.
    assign tx_free = (tx_count > CNT_W'(DEPTH)) ? '0
                   : (CNT_W+1)'(DEPTH) - {1'b0, tx_count};

    // Current set conditions for each flag.
    assign cond.ovf = ovf_pulse;
    assign cond.rxr = rx_count > rx_thr;
    assign cond.txr = tx_free >= {1'b0, tx_thr};

    // Clear request picked out of the written pattern.
    assign clr.ovf = clr_we && clr_data[OVF_BIT];
    assign clr.rxr = clr_we && clr_data[RXR_BIT];
    assign clr.txr = clr_we && clr_data[TXR_BIT];

    // Flag register: a clear loses to a condition that still holds.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr) | cond;
    end

    // Mask register keeps only the flag positions.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (mask_we) mask <= '{ovf: mask_wdata[OVF_BIT],
                                    rxr: mask_wdata[RXR_BIT],
                                    txr: mask_wdata[TXR_BIT]};
    end

    // Assemble the status word and the interrupt.
    always_comb begin
        event_word = '0;
        event_word[RXCNT_LSB +: CNT_W] = rx_count;
        event_word[TXCNT_LSB +: CNT_W] = tx_count;
        event_word[OVF_BIT] = flags.ovf;
        event_word[RXR_BIT] = flags.rxr;
        event_word[TXR_BIT] = flags.txr;
    end
    assign irq = |(flags & mask);

    assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |=> event_word[OVF_BIT]);

    assert_clear_works_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && clr_data[RXR_BIT] && !(rx_count > rx_thr)) |=> !event_word[RXR_BIT]);

    assert_mask_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_we && (mask_wdata & FLAG_BITS) == 32'd0) |=> !irq);

    assert_rx_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count > rx_thr) |=> event_word[RXR_BIT]);
endmodule

// File: rtl/spi_evt_status.sv
// Top of the SPI event status unit: receive FIFO with byte or word reads,
// plus the status word, mask and interrupt. Assumes DEPTH fits the six-bit
// count fields of the status word.
module spi_evt_status
    import spi_evt_pkg::*;
#(
    parameter int unsigned DEPTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_push,
    input  logic [7:0]       rx_in,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] rx_thr,
    input  logic [CNT_W-1:0] tx_thr,
    input  logic             evt_clr_we,
    input  logic [31:0]      evt_clr_data,
    input  logic             mask_we,
    input  logic [31:0]      mask_wdata,
    input  logic             rd_word,
    input  logic             rd_byte,
    output logic [31:0]      rd_data,
    output logic [31:0]      event_word,
    output logic             irq
);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [CW-1:0] rx_cnt;
    logic          rx_drop;

    spi_evt_rxfifo #(.DEPTH(DEPTH)) u_rxfifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (rx_push),
        .din     (rx_in),
        .rd_word (rd_word),
        .rd_byte (rd_byte),
        .rd_data (rd_data),
        .count   (rx_cnt),
        .drop    (rx_drop)
    );

    spi_evt_flags #(.DEPTH(DEPTH)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_count   (CNT_W'(rx_cnt)),
        .tx_count   (tx_count),
        .rx_thr     (rx_thr),
        .tx_thr     (tx_thr),
        .ovf_pulse  (rx_drop),
        .clr_we     (evt_clr_we),
        .clr_data   (evt_clr_data),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .event_word (event_word),
        .irq        (irq)
    );

    assert_reset_quiet_R11: assert property (@(posedge clk)
        !rst_n |=> (!irq && event_word[11:8] == 4'd0));
endmodule

// File: tb/spi_evt_status_test.sv
`timescale 1ns/1ps
module spi_evt_status_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_push = 1'b0;
    logic [7:0]  rx_in = '0;
    logic [5:0]  tx_count = 6'd32;
    logic [5:0]  rx_thr = 6'd3;
    logic [5:0]  tx_thr = 6'd4;
    logic        evt_clr_we = 1'b0;
    logic [31:0] evt_clr_data = '0;
    logic        mask_we = 1'b0;
    logic [31:0] mask_wdata = '0;
    logic        rd_word = 1'b0;
    logic        rd_byte = 1'b0;
    logic [31:0] rd_data, event_word;
    logic        irq;
    int          checks = 0;
    int          failures = 0;

    always #4 clk = ~clk;

    spi_evt_status uut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic push_byte(input logic [7:0] b);
        rx_push = 1'b1; rx_in = b; step(); rx_push = 1'b0;
    endtask

    task automatic read_op(input logic w, input logic b, output logic [31:0] d);
        rd_word = w; rd_byte = b; #1; d = rd_data; step();
        rd_word = 1'b0; rd_byte = 1'b0;
    endtask

    task automatic clear_flags(input logic [31:0] pat);
        evt_clr_we = 1'b1; evt_clr_data = pat; step(); evt_clr_we = 1'b0;
    endtask

    task automatic load_mask(input logic [31:0] m);
        mask_we = 1'b1; mask_wdata = m; step(); mask_we = 1'b0;
    endtask

    task automatic t_reset();
        step(); step();
        chk("R11 status word in reset", event_word, 32'h0020_0000);
        chk("R11 irq in reset", {31'd0, irq}, 32'd0);
        rst_n = 1'b1; step();
    endtask

    task automatic t_word_reads();
        logic [31:0] d;
        for (int i = 0; i < 5; i++) push_byte(8'h11 + 8'(i));
        chk("R1 rx count field", {26'd0, event_word[29:24]}, 32'd5);
        step();
        chk("R2 rx ready set", {31'd0, event_word[9]}, 32'd1);
        read_op(1'b1, 1'b0, d);
        chk("R7 full word", d, 32'h1112_1314);
        chk("R7 count after word", {26'd0, event_word[29:24]}, 32'd1);
        read_op(1'b1, 1'b0, d);
        chk("R8 short word", d, 32'h1500_0000);
        chk("R8 count after short", {26'd0, event_word[29:24]}, 32'd0);
        read_op(1'b1, 1'b0, d);
        chk("R10 empty word read", d, 32'd0);
        read_op(1'b0, 1'b1, d);
        chk("R10 empty byte read", d, 32'd0);
        chk("R10 count stays zero", {26'd0, event_word[29:24]}, 32'd0);
        clear_flags(32'hFFFF_FFFF);
        chk("R5 clear all", event_word, 32'h0020_0000);
    endtask

    task automatic t_threshold_bytes();
        logic [31:0] d;
        for (int i = 0; i < 3; i++) push_byte(8'hA1 + 8'(i));
        step();
        chk("R2 at threshold no flag", {31'd0, event_word[9]}, 32'd0);
        push_byte(8'hA4); step();
        chk("R2 above threshold flag", {31'd0, event_word[9]}, 32'd1);
        read_op(1'b0, 1'b1, d);
        chk("R9 byte read", d, 32'h0000_00A1);
        chk("R9 count after byte", {26'd0, event_word[29:24]}, 32'd3);
        read_op(1'b1, 1'b1, d);
        chk("R9 word wins", d, 32'hA2A3_A400);
        chk("R9 count after both", {26'd0, event_word[29:24]}, 32'd0);
        clear_flags(32'h0000_0200);
        chk("R5 rx ready cleared", {31'd0, event_word[9]}, 32'd0);
    endtask

    task automatic t_tx_room();
        tx_count = 6'd28; step(); step();
        chk("R3 room at threshold", {31'd0, event_word[8]}, 32'd1);
        clear_flags(32'h0000_0100); step();
        chk("R5 clear loses to live cond", {31'd0, event_word[8]}, 32'd1);
        tx_count = 6'd29; step(); step();
        chk("R1 tx count field", {26'd0, event_word[21:16]}, 32'd29);
        chk("R3 flag sticky", {31'd0, event_word[8]}, 32'd1);
        clear_flags(32'h0000_0100);
        chk("R5 clear with cond false", {31'd0, event_word[8]}, 32'd0);
        clear_flags(32'h0000_0000);
        chk("R5 zero pattern no effect", event_word & 32'h0000_0B00, 32'd0);
        tx_count = 6'd32; step();
    endtask

    task automatic t_overflow_irq();
        logic [31:0] d;
        for (int i = 0; i < 32; i++) push_byte(8'(i));
        chk("R4 full count", {26'd0, event_word[29:24]}, 32'd32);
        chk("R4 no overflow yet", {31'd0, event_word[11]}, 32'd0);
        push_byte(8'hEE);
        chk("R4 count unchanged", {26'd0, event_word[29:24]}, 32'd32);
        chk("R4 overflow flag", {31'd0, event_word[11]}, 32'd1);
        load_mask(32'h0000_0800);
        chk("R6 irq with mask", {31'd0, irq}, 32'd1);
        load_mask(32'h3F3F_F0FF);
        chk("R6 non-flag mask bits", {31'd0, irq}, 32'd0);
        load_mask(32'h0000_0200);
        chk("R6 rx ready irq", {31'd0, irq}, 32'd1);
        read_op(1'b1, 1'b0, d);
        chk("R7 first word after fill", d, 32'h0001_0203);
        for (int i = 0; i < 6; i++) read_op(1'b1, 1'b0, d);
        read_op(1'b1, 1'b0, d);
        chk("R4 dropped byte absent", d, 32'h1C1D_1E1F);
        clear_flags(32'hFFFF_FFFF);
        chk("R5 all flags cleared", event_word, 32'h0020_0000);
        chk("R6 irq drops", {31'd0, irq}, 32'd0);
        load_mask(32'd0);
    endtask

    initial begin
        t_reset();
        t_word_reads();
        t_threshold_bytes();
        t_tx_room();
        t_overflow_irq();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule